// File: doc/BRIEF.md
# Memory Thermal Trip Throttler

This block guards DRAM against overheating. It takes a memory temperature reading and compares it against three trip levels, warm, hot and critical, each with its own threshold and hysteresis. While warm or hot is active, the block gates the command scheduler through a permit signal. The permit opens for a programmable number of cycles out of every sixteen. When the critical level is reached, the block raises a shutdown request that stays set until reset, and it closes the permit entirely.

The temperature used for the comparison comes from one of two places, chosen by a control bit. One is a value written from outside, for example by a sideband sensor agent. The other is an internal estimate: an accumulator that rises with the weighted count of memory commands issued each cycle and falls by a fixed cooling step once per sample period. Software programs thresholds, hysteresis, throttle amounts and the source bit through a simple write port.

Top module: `mem_thermal_throttle`

## Requirements
- R1: After reset, `shutdown_req` is low and `cmd_permit` is high. The source is the external value, every threshold is 255, every hysteresis is 0 and both throttle amounts are 15.
- R2: A level becomes active on the clock edge after the selected temperature is strictly greater than its threshold. While no level is active and no shutdown is pending, `cmd_permit` is high.
- R3: While the hot level is active, the hot amount governs the permit, whether or not warm is active. Warm's amount applies only when warm is active and hot is not.
- R4: A throttle amount N (4 bits) lets `cmd_permit` be high on exactly N of any 16 consecutive cycles, so N = 0 blocks every cycle.
- R5: An active level clears only when temperature + hysteresis < threshold, and otherwise holds. If the hysteresis exceeds the threshold, the level cannot clear until reset.
- R6: Once the critical level is active, `shutdown_req` is set on the next edge and stays high until reset. While it is high, `cmd_permit` is low.
- R7: Bit 0 of address 0 selects the source: 0 means `ext_temp`, 1 means the activity estimate. While the estimate is selected, `ext_temp` has no effect.
- R8: The estimate accumulator (EST_W bits) adds `act_cnt`×ACT_WEIGHT every cycle. It subtracts COOL_DEC on one cycle out of every SAMPLE_PERIOD, saturating at 0 and at all-ones. The estimated temperature is the top 8 bits of the accumulator.
- R9: The register map is as follows. Address 0 is control. Addresses 1, 2 and 3 hold the warm, hot and critical levels, with the threshold in bits [7:0] and the hysteresis in bits [15:8]. Address 4 holds the amounts, warm in [3:0] and hot in [7:4]. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| ext_temp | input | 8 | Externally supplied temperature |
| act_cnt | input | CNT_W | Memory commands issued this cycle |
| cmd_permit | output | 1 | High when the scheduler may issue a command |
| shutdown_req | output | 1 | Sticky system shutdown request |

## Verification
The assertions check a set of cycle-level rules on every cycle:
- shutdown stays set once raised and always closes the permit;
- the warm level sets whenever the temperature exceeds its threshold, and holds inside its hysteresis band;
- the permit stays open with no active level;
- a zero warm amount blocks issue;
- the estimator neither wraps below zero nor overflows past its maximum.

Only the bench scenarios can show the following:
- the exact N-of-16 permit count for every amount;
- the full temperature sweep across both thresholds;
- hysteresis release points;
- the multi-thousand-cycle rise, saturation and cooling of the activity estimate;
- the source selection;
- the clearing of shutdown by reset.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
    localparam int TEMP_W   = 8;
    localparam int AMT_W    = 4;
    localparam int ADDR_W   = 3;
    localparam int NUM_LVL  = 3;
    localparam int LVL_WARM = 0;
    localparam int LVL_HOT  = 1;
    localparam int LVL_CRIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_WARM = 3'd1,
        A_HOT  = 3'd2,
        A_CRIT = 3'd3,
        A_AMT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [TEMP_W-1:0] thr;
        logic [TEMP_W-1:0] hyst;
    } trip_cfg_t;

    typedef struct packed {
        logic                          src_est;
        trip_cfg_t [NUM_LVL-1:0]       trip;
        logic [AMT_W-1:0]              warm_amt;
        logic [AMT_W-1:0]              hot_amt;
    } reg_state_t;

    typedef struct packed {
        logic active;
    } trip_state_t;

    typedef struct packed {
        logic [AMT_W-1:0] phase;
        logic             shut;
    } win_state_t;
endpackage

// File: rtl/mtt_regs.sv
module mtt_regs
    import mtt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic                          src_est,
    output trip_cfg_t [NUM_LVL-1:0]       trip_cfg,
    output logic [AMT_W-1:0]              warm_amt,
    output logic [AMT_W-1:0]              hot_amt
);
    localparam int HYST_LSB = TEMP_W;
    localparam int HYST_MSB = 2 * TEMP_W - 1;

    reg_state_t s_d, s_q, rst_s;

    always_comb begin
        rst_s.src_est = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            rst_s.trip[i].thr  = '1;
            rst_s.trip[i].hyst = '0;
        end
        rst_s.warm_amt = '1;
        rst_s.hot_amt  = '1;
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: s_d.src_est = wr_data[0];
                A_WARM: begin
                    s_d.trip[LVL_WARM].thr  = wr_data[TEMP_W-1:0];
                    s_d.trip[LVL_WARM].hyst = wr_data[HYST_MSB:HYST_LSB];
                end
                A_HOT: begin
                    s_d.trip[LVL_HOT].thr  = wr_data[TEMP_W-1:0];
                    s_d.trip[LVL_HOT].hyst = wr_data[HYST_MSB:HYST_LSB];
                end
                A_CRIT: begin
                    s_d.trip[LVL_CRIT].thr  = wr_data[TEMP_W-1:0];
                    s_d.trip[LVL_CRIT].hyst = wr_data[HYST_MSB:HYST_LSB];
                end
                A_AMT: begin
                    s_d.warm_amt = wr_data[AMT_W-1:0];
                    s_d.hot_amt  = wr_data[2*AMT_W-1:AMT_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= rst_s;
        else        s_q <= s_d;
    end

    assign src_est  = s_q.src_est;
    assign trip_cfg = s_q.trip;
    assign warm_amt = s_q.warm_amt;
    assign hot_amt  = s_q.hot_amt;
endmodule

// File: rtl/mtt_estimator.sv
module mtt_estimator
    import mtt_pkg::*;
#(
    parameter int EST_W         = 12,
    parameter int CNT_W         = 4,
    parameter int ACT_WEIGHT    = 1,
    parameter int COOL_DEC      = 16,
    parameter int SAMPLE_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  act_cnt,
    output logic [EST_W-1:0]  est_acc,
    output logic              sample_tick,
    output logic [TEMP_W-1:0] est_temp
);
    localparam int PER_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
    localparam int WIDE  = EST_W + CNT_W + 16;
    localparam logic [EST_W-1:0] EST_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [EST_W-1:0] acc;
    } est_state_t;

    est_state_t s_d, s_q;
    logic [WIDE-1:0] sum;
    logic            tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.per == PER_W'(SAMPLE_PERIOD - 1));
        s_d.per = tick ? '0 : s_q.per + 1'b1;
        sum = WIDE'(s_q.acc) + WIDE'(act_cnt) * WIDE'(ACT_WEIGHT);
        if (tick) begin
            sum = (sum > WIDE'(COOL_DEC)) ? sum - WIDE'(COOL_DEC) : '0;
        end
        if (sum > WIDE'(EST_MAX)) begin
            sum = WIDE'(EST_MAX);
        end
        s_d.acc = sum[EST_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign est_acc     = s_q.acc;
    assign sample_tick = tick;
    assign est_temp    = s_q.acc[EST_W-1 -: TEMP_W];
endmodule

// File: rtl/mtt_trip.sv
module mtt_trip
    import mtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    input  trip_cfg_t         cfg,
    output logic              lvl
);
    trip_state_t s_d, s_q;
    logic [TEMP_W:0] low_sum;

    always_comb begin
        s_d     = s_q;
        low_sum = {1'b0, temp} + {1'b0, cfg.hyst};
        if (temp > cfg.thr) begin
            s_d.active = 1'b1;
        end else if (low_sum < {1'b0, cfg.thr}) begin
            s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.active;
endmodule

// File: rtl/mtt_window.sv
module mtt_window
    import mtt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] lvl,
    input  logic [AMT_W-1:0]   warm_amt,
    input  logic [AMT_W-1:0]   hot_amt,
    output logic               permit,
    output logic               shutdown
);
    win_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.phase = s_q.phase + 1'b1;
        s_d.shut  = s_q.shut | lvl[LVL_CRIT];
    end

    always_comb begin
        if (s_q.shut)               permit = 1'b0;
        else if (lvl[LVL_HOT])      permit = (s_q.phase < hot_amt);
        else if (lvl[LVL_WARM])     permit = (s_q.phase < warm_amt);
        else                        permit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shutdown = s_q.shut;
endmodule

// File: rtl/mem_thermal_throttle.sv
module mem_thermal_throttle
    import mtt_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int CNT_W         = 4,
    parameter int EST_W         = 12,
    parameter int ACT_WEIGHT    = 1,
    parameter int COOL_DEC      = 16,
    parameter int SAMPLE_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TEMP_W-1:0] ext_temp,
    input  logic [CNT_W-1:0]  act_cnt,
    output logic              cmd_permit,
    output logic              shutdown_req
);
    logic                    src_est;
    trip_cfg_t [NUM_LVL-1:0] trip_cfg;
    logic [AMT_W-1:0]        warm_amt, hot_amt;
    logic [EST_W-1:0]        est_acc;
    logic                    sample_tick;
    logic [TEMP_W-1:0]       est_temp, sel_temp;
    logic [NUM_LVL-1:0]      lvl;
    logic [TEMP_W-1:0]       warm_thr, warm_hyst;
    logic                    warm_lvl, hot_lvl;

    mtt_regs #(.DATA_W(DATA_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .src_est  (src_est),
        .trip_cfg (trip_cfg),
        .warm_amt (warm_amt),
        .hot_amt  (hot_amt)
    );

    mtt_estimator #(
        .EST_W         (EST_W),
        .CNT_W         (CNT_W),
        .ACT_WEIGHT    (ACT_WEIGHT),
        .COOL_DEC      (COOL_DEC),
        .SAMPLE_PERIOD (SAMPLE_PERIOD)
    ) i_est (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_cnt     (act_cnt),
        .est_acc     (est_acc),
        .sample_tick (sample_tick),
        .est_temp    (est_temp)
    );

    assign sel_temp = src_est ? est_temp : ext_temp;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_trip
        mtt_trip i_trip (
            .clk   (clk),
            .rst_n (rst_n),
            .temp  (sel_temp),
            .cfg   (trip_cfg[g]),
            .lvl   (lvl[g])
        );
    end

    mtt_window i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .warm_amt (warm_amt),
        .hot_amt  (hot_amt),
        .permit   (cmd_permit),
        .shutdown (shutdown_req)
    );

    assign warm_thr  = trip_cfg[LVL_WARM].thr;
    assign warm_hyst = trip_cfg[LVL_WARM].hyst;
    assign warm_lvl  = lvl[LVL_WARM];
    assign hot_lvl   = lvl[LVL_HOT];
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker
    import mtt_pkg::*;
#(
    parameter int EST_W = 12,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TEMP_W-1:0] temp,
    input logic [TEMP_W-1:0] warm_thr,
    input logic [TEMP_W-1:0] warm_hyst,
    input logic              warm_lvl,
    input logic              hot_lvl,
    input logic [AMT_W-1:0]  warm_amt,
    input logic [EST_W-1:0]  est_acc,
    input logic [CNT_W-1:0]  act_cnt,
    input logic              sample_tick,
    input logic              cmd_permit,
    input logic              shutdown_req
);
    p_shutdown_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    p_shutdown_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> !cmd_permit);

    p_warm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (temp > warm_thr) |=> warm_lvl);

    p_idle_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_lvl && !hot_lvl && !shutdown_req) |-> cmd_permit);

    p_warm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_lvl && (({1'b0, temp} + {1'b0, warm_hyst}) >= {1'b0, warm_thr})) |=> warm_lvl);

    p_zero_amount_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_lvl && !hot_lvl && (warm_amt == '0)) |-> !cmd_permit);

    p_est_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((est_acc == '1) && (act_cnt != '0) && !sample_tick) |=> (est_acc == '1));

    p_est_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((est_acc == '0) && (act_cnt == '0)) |=> (est_acc == '0));
endmodule

bind mem_thermal_throttle mtt_checker #(.EST_W(EST_W), .CNT_W(CNT_W)) i_mtt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp         (sel_temp),
    .warm_thr     (warm_thr),
    .warm_hyst    (warm_hyst),
    .warm_lvl     (warm_lvl),
    .hot_lvl      (hot_lvl),
    .warm_amt     (warm_amt),
    .est_acc      (est_acc),
    .act_cnt      (act_cnt),
    .sample_tick  (sample_tick),
    .cmd_permit   (cmd_permit),
    .shutdown_req (shutdown_req)
);

// File: tb/test_mem_thermal_throttle.sv
module test_mem_thermal_throttle;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [7:0]  ext_temp;
    logic [3:0]  act_cnt;
    logic        cmd_permit;
    logic        shutdown_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mem_thermal_throttle i_mem_thermal_throttle (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ext_temp     (ext_temp),
        .act_cnt      (act_cnt),
        .cmd_permit   (cmd_permit),
        .shutdown_req (shutdown_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic trip(input int a, input int thr, input int hyst);
        wr(a, (hyst << 8) | thr);
    endtask

    task automatic count16(output int c);
        c = 0;
        repeat (16) begin
            @(negedge clk);
            c += int'(cmd_permit);
        end
    endtask

    task automatic expect_count(input string req, input int exp);
        int c;
        count16(c);
        check(c == exp, req, c, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int exp;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_temp = '0; act_cnt = '0;
        do_reset();

        // R1: reset state
        check(shutdown_req == 1'b0, "R1 shutdown", int'(shutdown_req), 0);
        expect_count("R1 permit open", 16);
        ext_temp = 8'd255;
        idle(3);
        expect_count("R1 max threshold not crossed", 16);
        ext_temp = 8'd0;

        // R9 layout, R2/R4: warm amount sweep
        trip(1, 100, 0);
        trip(2, 200, 0);
        trip(3, 255, 0);
        ext_temp = 8'd150;
        idle(3);
        for (int n = 0; n < 16; n++) begin
            wr(4, (15 << 4) | n);
            idle(1);
            expect_count($sformatf("R4 warm amount %0d", n), n);
        end

        // R3: hot amount sweep with warm amount 5
        ext_temp = 8'd220;
        idle(3);
        for (int n = 0; n < 16; n++) begin
            wr(4, (n << 4) | 5);
            idle(1);
            expect_count($sformatf("R3 hot amount %0d", n), n);
        end

        // R2/R3: temperature sweep across both thresholds
        wr(4, (12 << 4) | 4);
        for (int t = 0; t < 256; t++) begin
            ext_temp = 8'd0;
            idle(3);
            ext_temp = 8'(t);
            idle(3);
            exp = (t > 200) ? 12 : ((t > 100) ? 4 : 16);
            expect_count($sformatf("R2 sweep temp %0d", t), exp);
        end

        // R9: unmapped addresses ignored
        ext_temp = 8'd150;
        idle(3);
        wr(5, 0); wr(6, 0); wr(7, 0);
        idle(1);
        expect_count("R9 unmapped write", 4);

        // R5: hysteresis band
        ext_temp = 8'd0;
        idle(3);
        trip(1, 100, 10);
        ext_temp = 8'd101; idle(3);
        expect_count("R5 set", 4);
        ext_temp = 8'd95;  idle(3);
        expect_count("R5 hold 95", 4);
        ext_temp = 8'd90;  idle(3);
        expect_count("R5 hold 90", 4);
        ext_temp = 8'd89;  idle(3);
        expect_count("R5 release 89", 16);
        trip(1, 100, 200);
        ext_temp = 8'd101; idle(3);
        expect_count("R5 floor set", 4);
        ext_temp = 8'd0;   idle(3);
        expect_count("R5 floor hold", 4);
        trip(1, 100, 0);
        idle(2);
        expect_count("R5 release after hyst 0", 16);

        // R7: source select ignores external value
        wr(0, 1);
        ext_temp = 8'd150; idle(3);
        expect_count("R7 external ignored", 16);
        wr(0, 0);
        idle(3);
        expect_count("R7 external selected", 4);
        ext_temp = 8'd0;
        idle(3);

        // R8: estimator rise, saturation, cooling and floor
        wr(0, 1);
        trip(1, 50, 0);
        act_cnt = 4'd15; idle(3); act_cnt = 4'd0;
        idle(3);
        expect_count("R8 small rise below warm", 16);
        act_cnt = 4'd15; idle(100); act_cnt = 4'd0;
        idle(3);
        expect_count("R8 rise above warm", 4);
        trip(2, 254, 0);
        act_cnt = 4'd15; idle(600);
        expect_count("R8 saturate at max", 12);
        act_cnt = 4'd0; idle(500);
        expect_count("R8 partial cooling", 4);
        idle(4000);
        expect_count("R8 full cooling", 16);
        trip(1, 0, 0);
        idle(3);
        expect_count("R8 floor at zero", 16);

        // R6: critical shutdown sticky
        wr(0, 0);
        trip(1, 100, 0);
        trip(2, 200, 0);
        trip(3, 230, 0);
        ext_temp = 8'd231; idle(3);
        check(shutdown_req == 1'b1, "R6 shutdown set", int'(shutdown_req), 1);
        expect_count("R6 permit closed", 0);
        ext_temp = 8'd0; idle(20);
        check(shutdown_req == 1'b1, "R6 shutdown sticky", int'(shutdown_req), 1);
        expect_count("R6 permit stays closed", 0);
        do_reset();
        check(shutdown_req == 1'b0, "R1 shutdown cleared by reset", int'(shutdown_req), 0);
        expect_count("R1 permit after reset", 16);

        summary();
        $finish;
    end
endmodule